// File: doc/BRIEF.md
# Background Debug Command Sequencer

This block is the target-side command engine of a single-wire background debug port. The wire-level pulse timing is handled elsewhere. The sequencer sees one strobe per bit received from the host and one strobe per bit the host pulls back. From these it assembles an 8-bit command code and then works through the phases that code calls for: a 16-bit address from the host, 8 or 16 bits of write data from the host, a fixed wait, and 8 or 16 bits of read data returned to the host. Every field moves most significant bit first.

The commands reach three things: a byte-wide memory port, an 8-bit debug status/control register and a 16-bit breakpoint register. The status register shows whether the target is halted in background mode. Some commands are accepted only while the target is halted: memory reads and writes, and the command that resumes the target. A command of that kind that arrives while the target runs is thrown away, and a reject flag pulses for one cycle. The remaining commands are accepted in either mode.

Top module: `dbg_cmd_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the block to waiting for the first bit of a command code. It discards any partly received bits, clears the breakpoint register and the status control bits, clears bgMode (running), and drives shiftOutValid and cmdReject low.
- R2: The command code, the address, the write data and the read data all move most significant bit first. Each accepted shiftInStb adds shiftInBit as the new least significant bit. shiftOutBit shows the most significant bit that has not yet been sent, and each shiftOutStb advances it by one bit.
- R3: Command encodings and their phases. 0xE0 reads a memory byte: address, wait, 8 read bits. 0xC0 writes a memory byte: address, 8 write bits, wait. 0xE4 reads status (8 read bits). 0xC4 writes status (8 write bits). 0xE2 reads the breakpoint (16 read bits). 0xC2 writes the breakpoint (16 write bits). 0x08 resumes (go). 0x90 halts (enters background mode).
- R4: The wait lasts exactly WAIT_CYCLES clocks. For a memory read, shiftOutValid first rises WAIT_CYCLES clock edges after the edge that takes the last address bit. For a memory write, the next command code is accepted only after those WAIT_CYCLES clocks.
- R5: A status read returns bgMode in bit 7 and the stored control bits in bits 6:0. A status write stores bits 6:0 only; bit 7 of the written byte has no effect.
- R6: A breakpoint write stores all 16 bits, and bkptAddr shows them from the next cycle. A breakpoint read returns the stored value.
- R7: While bgMode is 0, the codes 0xE0, 0xC0 and 0x08 are rejected, and so is any code not listed in R3. cmdReject is high for exactly the one cycle after the last code bit. No memory access or register change takes place, and the block waits for a new code.
- R8: The status and breakpoint commands and 0x90 are accepted both while halted and while running.
- R9: The go and halt commands change bgMode (0 and 1 respectively) in the cycle after their last code bit, when the frame ends.
- R10: A shiftInStb during the wait or the read-out phase is ignored. A shiftOutStb outside the read-out phase is ignored.
- R11: A memory write pulses memWrEn for one cycle, with memAddr and memWrData valid, on the clock edge that takes the last write-data bit. A memory read pulses memRdEn for one cycle at the start of the wait and samples memRdData in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous reset, active high |
| shiftInStb | input | 1 | One host-to-target bit is present this cycle |
| shiftInBit | input | 1 | Value of that bit |
| shiftOutStb | input | 1 | Host takes the current output bit this cycle |
| shiftOutBit | output | 1 | Current target-to-host bit |
| shiftOutValid | output | 1 | Read-out phase active |
| cmdReject | output | 1 | One-cycle pulse when a command is discarded |
| bgMode | output | 1 | 1 when halted in background mode |
| bkptAddr | output | 16 | Breakpoint register value |
| memAddr | output | 16 | Memory address |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | 8 | Memory read data, valid in the cycle of memRdEn |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write data |

## Verification
The bench builds the block with the default WAIT_CYCLES of 16 and the fixed field widths. With these values it can count the exact gap between the last address bit and the first read bit, and it can push a full 16-bit breakpoint pattern through both directions. Its memory model decodes the low six address bits, so two distinct addresses show that the address field is assembled most significant bit first. Short wait values would hide an off-by-one error in the wait counter, so the default is kept.

// File: rtl/dbg_cmd_seq_pkg.sv
package dbg_cmd_seq_pkg;
  localparam int CODE_W = 8;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  localparam logic [CODE_W-1:0] CMD_RD_MEM  = 8'hE0;
  localparam logic [CODE_W-1:0] CMD_WR_MEM  = 8'hC0;
  localparam logic [CODE_W-1:0] CMD_RD_STAT = 8'hE4;
  localparam logic [CODE_W-1:0] CMD_WR_STAT = 8'hC4;
  localparam logic [CODE_W-1:0] CMD_RD_BKPT = 8'hE2;
  localparam logic [CODE_W-1:0] CMD_WR_BKPT = 8'hC2;
  localparam logic [CODE_W-1:0] CMD_GO      = 8'h08;
  localparam logic [CODE_W-1:0] CMD_HALT    = 8'h90;

  typedef enum logic [2:0] {PH_CODE, PH_ADDR, PH_WDATA, PH_WAIT, PH_RDATA} phase_e;
  typedef enum logic [1:0] {SZ_NONE, SZ_BYTE, SZ_WORD} size_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_MEM, TGT_STAT, TGT_BKPT} target_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_GO, ACT_HALT} act_e;

  typedef struct packed {
    logic    known;
    logic    bgOnly;
    logic    hasAddr;
    logic    hasWait;
    size_e   wrSize;
    size_e   rdSize;
    target_e tgt;
    act_e    act;
  } cmd_info_t;

  typedef struct packed {
    logic shiftIn;
    logic clrIn;
    logic latchAddr;
    logic memWr;
    logic memRd;
    logic wrStat;
    logic wrBkpt;
    logic loadStat;
    logic loadBkpt;
    logic shiftOut;
    logic setBg;
    logic clrBg;
  } strobe_t;

  function automatic cmd_info_t decodeCmd(input logic [CODE_W-1:0] code);
    cmd_info_t d;
    d = '0;
    d.known = 1'b1;
    case (code)
      CMD_RD_MEM: begin
        d.bgOnly = 1'b1; d.hasAddr = 1'b1; d.hasWait = 1'b1;
        d.rdSize = SZ_BYTE; d.tgt = TGT_MEM;
      end
      CMD_WR_MEM: begin
        d.bgOnly = 1'b1; d.hasAddr = 1'b1; d.hasWait = 1'b1;
        d.wrSize = SZ_BYTE; d.tgt = TGT_MEM;
      end
      CMD_RD_STAT: begin d.rdSize = SZ_BYTE; d.tgt = TGT_STAT; end
      CMD_WR_STAT: begin d.wrSize = SZ_BYTE; d.tgt = TGT_STAT; end
      CMD_RD_BKPT: begin d.rdSize = SZ_WORD; d.tgt = TGT_BKPT; end
      CMD_WR_BKPT: begin d.wrSize = SZ_WORD; d.tgt = TGT_BKPT; end
      CMD_GO:      begin d.bgOnly = 1'b1; d.act = ACT_GO; end
      CMD_HALT:    d.act = ACT_HALT;
      default:     d.known = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [CNT_W-1:0] lastIdx(input size_e sz);
    return (sz == SZ_WORD) ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
  endfunction
endpackage

// File: rtl/dbg_cmd_seq_ctrl.sv
module dbg_cmd_seq_ctrl
  import dbg_cmd_seq_pkg::*;
#(
  parameter int WAIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftInStb,
  input  logic              shiftOutStb,
  input  logic              bgMode,
  input  logic [CODE_W-1:0] codeNext,
  output strobe_t           st,
  output logic              shiftOutValid,
  output logic              cmdReject
);
  localparam int WAIT_W = $clog2(WAIT_CYCLES) + 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES - 1);

  phase_e            phase, phaseNext;
  logic [CNT_W-1:0]  bitCnt, bitCntNext;
  logic [WAIT_W-1:0] waitCnt, waitCntNext;
  cmd_info_t         cmdReg, cmdNext, decoded;
  logic              rejectNext;

  assign decoded       = decodeCmd(codeNext);
  assign shiftOutValid = (phase == PH_RDATA);

  always_comb begin
    st          = '0;
    phaseNext   = phase;
    bitCntNext  = bitCnt;
    waitCntNext = waitCnt;
    cmdNext     = cmdReg;
    rejectNext  = 1'b0;
    unique case (phase)
      PH_CODE: if (shiftInStb) begin
        st.shiftIn = 1'b1;
        if (bitCnt == CNT_W'(CODE_W - 1)) begin
          st.clrIn   = 1'b1;
          bitCntNext = '0;
          cmdNext    = decoded;
          if (!decoded.known || (decoded.bgOnly && !bgMode)) begin
            rejectNext = 1'b1;
            cmdNext    = '0;
          end else begin
            st.clrBg = (decoded.act == ACT_GO);
            st.setBg = (decoded.act == ACT_HALT);
            if (decoded.hasAddr) phaseNext = PH_ADDR;
            else if (decoded.wrSize != SZ_NONE) phaseNext = PH_WDATA;
            else if (decoded.rdSize != SZ_NONE) begin
              phaseNext   = PH_RDATA;
              st.loadStat = (decoded.tgt == TGT_STAT);
              st.loadBkpt = (decoded.tgt == TGT_BKPT);
            end
          end
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      PH_ADDR: if (shiftInStb) begin
        st.shiftIn = 1'b1;
        if (bitCnt == CNT_W'(ADDR_W - 1)) begin
          st.clrIn     = 1'b1;
          st.latchAddr = 1'b1;
          bitCntNext   = '0;
          waitCntNext  = '0;
          if (cmdReg.wrSize != SZ_NONE) phaseNext = PH_WDATA;
          else if (cmdReg.hasWait)      phaseNext = PH_WAIT;
          else                          phaseNext = PH_RDATA;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      PH_WDATA: if (shiftInStb) begin
        st.shiftIn = 1'b1;
        if (bitCnt == lastIdx(cmdReg.wrSize)) begin
          st.clrIn    = 1'b1;
          st.memWr    = (cmdReg.tgt == TGT_MEM);
          st.wrStat   = (cmdReg.tgt == TGT_STAT);
          st.wrBkpt   = (cmdReg.tgt == TGT_BKPT);
          bitCntNext  = '0;
          waitCntNext = '0;
          phaseNext   = cmdReg.hasWait ? PH_WAIT : PH_CODE;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      PH_WAIT: begin
        st.memRd = (waitCnt == '0) && (cmdReg.tgt == TGT_MEM) && (cmdReg.rdSize != SZ_NONE);
        if (waitCnt == WAIT_LAST) begin
          bitCntNext = '0;
          phaseNext  = (cmdReg.rdSize != SZ_NONE) ? PH_RDATA : PH_CODE;
        end else begin
          waitCntNext = waitCnt + 1'b1;
        end
      end
      PH_RDATA: if (shiftOutStb) begin
        st.shiftOut = 1'b1;
        if (bitCnt == lastIdx(cmdReg.rdSize)) begin
          bitCntNext = '0;
          phaseNext  = PH_CODE;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      default: phaseNext = PH_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CODE;
      bitCnt    <= '0;
      waitCnt   <= '0;
      cmdReg    <= '0;
      cmdReject <= 1'b0;
    end else begin
      phase     <= phaseNext;
      bitCnt    <= bitCntNext;
      waitCnt   <= waitCntNext;
      cmdReg    <= cmdNext;
      cmdReject <= rejectNext;
    end
  end

  // R7
  reject_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmdReject |=> !cmdReject);

  // R4
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && phaseNext != PH_WAIT) |-> (waitCnt == WAIT_LAST));

  // R9
  mode_at_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bgMode)) |-> (phase == PH_CODE && bitCnt == '0));

  // R10
  readout_has_size_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RDATA) |-> (cmdReg.rdSize != SZ_NONE));
endmodule

// File: rtl/dbg_cmd_seq_dp.sv
module dbg_cmd_seq_dp
  import dbg_cmd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic              shiftInBit,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [CODE_W-1:0] codeNext,
  output logic              shiftOutBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [WORD_W-1:0] bkptAddr,
  output logic              bgMode
);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] inShift, inNext, outShift, bkptReg;
  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-2:0] ctlReg;
  logic              bgReg;

  assign inNext = {inShift[WORD_W-2:0], shiftInBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      inShift  <= '0;
      outShift <= '0;
      bkptReg  <= '0;
      addrReg  <= '0;
      ctlReg   <= '0;
      bgReg    <= 1'b0;
    end else begin
      if (st.clrIn)        inShift <= '0;
      else if (st.shiftIn) inShift <= inNext;
      if (st.latchAddr) addrReg <= inNext[ADDR_W-1:0];
      if (st.wrStat)    ctlReg  <= inNext[BYTE_W-2:0];
      if (st.wrBkpt)    bkptReg <= inNext;
      if (st.setBg)      bgReg <= 1'b1;
      else if (st.clrBg) bgReg <= 1'b0;
      if (st.memRd)         outShift <= {memRdData, {PAD_W{1'b0}}};
      else if (st.loadStat) outShift <= {bgReg, ctlReg, {PAD_W{1'b0}}};
      else if (st.loadBkpt) outShift <= bkptReg;
      else if (st.shiftOut) outShift <= {outShift[WORD_W-2:0], 1'b0};
    end
  end

  assign codeNext    = inNext[CODE_W-1:0];
  assign shiftOutBit = outShift[WORD_W-1];
  assign memAddr     = addrReg;
  assign memWrEn     = st.memWr;
  assign memWrData   = inNext[BYTE_W-1:0];
  assign memRdEn     = st.memRd;
  assign bkptAddr    = bkptReg;
  assign bgMode      = bgReg;

  // R7
  mem_only_halted_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrEn || memRdEn) |-> bgReg);

  // R11
  mem_single_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memWrEn, memRdEn}));

  // R6
  bkpt_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bkptReg)) |-> $past(st.wrBkpt));
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_cmd_seq_pkg::*;
#(
  parameter int WAIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftInStb,
  input  logic        shiftInBit,
  input  logic        shiftOutStb,
  output logic        shiftOutBit,
  output logic        shiftOutValid,
  output logic        cmdReject,
  output logic        bgMode,
  output logic [15:0] bkptAddr,
  output logic [15:0] memAddr,
  output logic        memRdEn,
  input  logic [7:0]  memRdData,
  output logic        memWrEn,
  output logic [7:0]  memWrData
);
  strobe_t           st;
  logic [CODE_W-1:0] codeNext;

  dbg_cmd_seq_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .shiftInStb(shiftInStb), .shiftOutStb(shiftOutStb),
    .bgMode(bgMode), .codeNext(codeNext), .st(st),
    .shiftOutValid(shiftOutValid), .cmdReject(cmdReject)
  );

  dbg_cmd_seq_dp uDp (
    .clk(clk), .rst(rst), .st(st), .shiftInBit(shiftInBit), .memRdData(memRdData),
    .codeNext(codeNext), .shiftOutBit(shiftOutBit), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdEn(memRdEn),
    .bkptAddr(bkptAddr), .bgMode(bgMode)
  );
endmodule

// File: tb/tb_dbg_cmd_seq.sv
module tb_dbg_cmd_seq;
  localparam int WAIT = 16;
  localparam int NV   = 20;

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic        hasAddr;
    logic [4:0]  wrBits;
    logic [4:0]  rdBits;
    logic        hasWait;
    logic [15:0] expRd;
    logic        expRej;
    logic        expBg;
    logic [3:0]  req;
  } vec_t;

  // Frame table; req names the requirement each row checks.
  localparam vec_t VECS [NV] = '{
    '{8'hE4, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd8,  1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 reset status
    '{8'hC0, 16'h0012, 16'h005A, 1'b1, 5'd8,  5'd0,  1'b1, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7 mem write while running
    '{8'hE0, 16'h0012, 16'h0000, 1'b1, 5'd0,  5'd8,  1'b1, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7 mem read while running
    '{8'h08, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7 go while running
    '{8'h90, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 4'd9},  // R9 halt
    '{8'hE4, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd8,  1'b0, 16'h0080, 1'b0, 1'b1, 4'd5},  // R5 bit 7 shows halt
    '{8'hC4, 16'h0000, 16'h0095, 1'b0, 5'd8,  5'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 4'd5},  // R5 write ctl
    '{8'hE4, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd8,  1'b0, 16'h0095, 1'b0, 1'b1, 4'd5},  // R5 readback
    '{8'hC0, 16'h0012, 16'h005A, 1'b1, 5'd8,  5'd0,  1'b1, 16'h0000, 1'b0, 1'b1, 4'd11}, // R11 mem write
    '{8'hE0, 16'h0012, 16'h0000, 1'b1, 5'd0,  5'd8,  1'b1, 16'h005A, 1'b0, 1'b1, 4'd2},  // R2 mem read
    '{8'hC2, 16'h0000, 16'hBEEF, 1'b0, 5'd16, 5'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 bkpt write
    '{8'hE2, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd16, 1'b0, 16'hBEEF, 1'b0, 1'b1, 4'd6},  // R6 bkpt read
    '{8'hC0, 16'h0033, 16'h00C3, 1'b1, 5'd8,  5'd0,  1'b1, 16'h0000, 1'b0, 1'b1, 4'd11}, // R11 second address
    '{8'hE0, 16'h0033, 16'h0000, 1'b1, 5'd0,  5'd8,  1'b1, 16'h00C3, 1'b0, 1'b1, 4'd2},  // R2
    '{8'hE0, 16'h0012, 16'h0000, 1'b1, 5'd0,  5'd8,  1'b1, 16'h005A, 1'b0, 1'b1, 4'd3},  // R3 encodings
    '{8'h08, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd0,  1'b0, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 go
    '{8'hE4, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd8,  1'b0, 16'h0015, 1'b0, 1'b0, 4'd5},  // R5 bit 7 cleared
    '{8'hC2, 16'h0000, 16'h1234, 1'b0, 5'd16, 5'd0,  1'b0, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 running
    '{8'hE2, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd16, 1'b0, 16'h1234, 1'b0, 1'b0, 4'd8},  // R8
    '{8'h55, 16'h0000, 16'h0000, 1'b0, 5'd0,  5'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 4'd7}   // R7 unknown code
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftInStb = 1'b0, shiftInBit = 1'b0, shiftOutStb = 1'b0;
  logic shiftOutBit, shiftOutValid, cmdReject, bgMode, memRdEn, memWrEn;
  logic [15:0] bkptAddr, memAddr;
  logic [7:0]  memRdData, memWrData;
  logic [7:0]  mem [64];
  int tests = 0, fails = 0, cycles = 0, wrCount = 0, rdCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_cmd_seq #(.WAIT_CYCLES(WAIT)) dut (
    .clk(clk), .rst(rst), .shiftInStb(shiftInStb), .shiftInBit(shiftInBit),
    .shiftOutStb(shiftOutStb), .shiftOutBit(shiftOutBit), .shiftOutValid(shiftOutValid),
    .cmdReject(cmdReject), .bgMode(bgMode), .bkptAddr(bkptAddr), .memAddr(memAddr),
    .memRdEn(memRdEn), .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData)
  );

  assign memRdData = mem[memAddr[5:0]];
  always_ff @(posedge clk) if (memWrEn) mem[memAddr[5:0]] <= memWrData;

  always @(posedge clk) begin
    if (memWrEn) wrCount <= wrCount + 1;
    if (memRdEn) rdCount <= rdCount + 1;
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shiftInStb = 1'b1;
      shiftInBit = v[n-1-i];
    end
    @(negedge clk);
    shiftInStb = 1'b0;
    shiftInBit = 1'b0;
  endtask

  task automatic recvBits(input int n, output logic [15:0] r, output bit ok);
    int guard = 0;
    r = '0;
    while (!shiftOutValid && guard < WAIT + 8) begin
      @(negedge clk);
      guard++;
    end
    ok = shiftOutValid;
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        r = {r[14:0], shiftOutBit};
        shiftOutStb = 1'b1;
        @(negedge clk);
      end
    end
    shiftOutStb = 1'b0;
  endtask

  task automatic readStat(input logic [15:0] exp, input int req, input string what);
    logic [15:0] r; bit ok;
    sendBits(16'h00E4, 8);
    recvBits(8, r, ok);
    check(ok && r == exp, req, what, r, exp);
  endtask

  initial begin
    logic [15:0] r;
    bit ok;
    int w0, r0, cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    check(bgMode == 1'b0 && bkptAddr == 16'h0 && !shiftOutValid && !cmdReject, 1,
          "reset outputs", {bgMode, shiftOutValid, cmdReject, bkptAddr[12:0]}, 16'h0);

    for (int v = 0; v < NV; v++) begin
      w0 = wrCount; r0 = rdCount;
      sendBits({8'h00, VECS[v].code}, 8);
      check(cmdReject == VECS[v].expRej, VECS[v].req, "reject flag", {15'h0, cmdReject},
            {15'h0, VECS[v].expRej});
      check(bgMode == VECS[v].expBg, VECS[v].req, "mode", {15'h0, bgMode}, {15'h0, VECS[v].expBg});
      if (VECS[v].expRej) begin
        @(negedge clk);
        // R7: discarded command touches nothing and the pulse is one cycle wide
        check(wrCount == w0 && rdCount == r0 && !cmdReject && !shiftOutValid, 7,
              "reject side effects", 16'(wrCount - w0 + rdCount - r0), 16'h0);
      end else begin
        if (VECS[v].hasAddr) sendBits(VECS[v].addr, 16);
        if (VECS[v].wrBits != 0) sendBits(VECS[v].wdata, int'(VECS[v].wrBits));
        if (VECS[v].hasWait && VECS[v].rdBits == 0) repeat (WAIT + 1) @(negedge clk);
        if (VECS[v].rdBits != 0) begin
          recvBits(int'(VECS[v].rdBits), r, ok);
          check(ok && r == VECS[v].expRd, VECS[v].req, "read data", r, VECS[v].expRd);
        end
      end
      @(negedge clk);
    end

    // R6: breakpoint register visible at its port
    check(bkptAddr == 16'h1234, 6, "bkptAddr port", bkptAddr, 16'h1234);

    // R4: exact wait before read data
    sendBits(16'h0090, 8);
    sendBits(16'h00E0, 8);
    w0 = rdCount;
    sendBits(16'h0033, 16);
    cnt = 0;
    while (!shiftOutValid && cnt < WAIT + 8) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == WAIT, 4, "wait length", 16'(cnt), 16'(WAIT));
    recvBits(8, r, ok);
    check(ok && r == 16'h00C3, 4, "read after wait", r, 16'h00C3);
    // R11: one read strobe per memory read
    check(rdCount == w0 + 1, 11, "read strobes", 16'(rdCount - w0), 16'h1);

    // R10: input bits during a write's wait are ignored
    w0 = wrCount;
    sendBits(16'h00C0, 8);
    sendBits(16'h0040, 16);
    sendBits(16'h0077, 8);
    check(wrCount == w0 + 1, 11, "write strobes", 16'(wrCount - w0), 16'h1);
    sendBits(16'h00C2, 8);
    repeat (WAIT) @(negedge clk);
    readStat(16'h0095, 10, "status after ignored bits");
    check(bkptAddr == 16'h1234, 10, "bkpt after ignored bits", bkptAddr, 16'h1234);
    sendBits(16'h00E0, 8);
    sendBits(16'h0040, 16);
    recvBits(8, r, ok);
    check(ok && r == 16'h0077, 11, "written byte", r, 16'h0077);

    // R10: input strobes during read-out and output strobes while idle are ignored
    sendBits(16'h00E2, 8);
    for (int i = 0; i < 5; i++) begin
      shiftInStb = 1'b1; shiftInBit = 1'b1;
      @(negedge clk);
    end
    shiftInStb = 1'b0; shiftInBit = 1'b0;
    recvBits(16, r, ok);
    check(ok && r == 16'h1234, 10, "readout with stray inputs", r, 16'h1234);
    for (int i = 0; i < 3; i++) begin
      shiftOutStb = 1'b1;
      @(negedge clk);
    end
    shiftOutStb = 1'b0;
    readStat(16'h0095, 10, "status after stray outputs");

    // R1: reset in the middle of a code
    sendBits(16'h0009, 4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(bgMode == 1'b0 && bkptAddr == 16'h0 && !shiftOutValid && !cmdReject, 1,
          "mid-frame reset", bkptAddr, 16'h0);
    readStat(16'h0000, 1, "status after reset");
    sendBits(16'h00E2, 8);
    recvBits(16, r, ok);
    check(ok && r == 16'h0000, 1, "bkpt after reset", r, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule